// File: doc/BRIEF.md
# Configuration Readback Serial Sequencer

This block is the digital side of a converter's serial configuration port. The host shifts a 16-bit configuration word in on a serial data line while holding a write-enable high, one bit per rising edge of its data clock. On the sixteenth bit the word is stored. From the next clock edge on, the block serializes a readback frame onto one data-out line, with one bit per rising edge of the same clock.

A readback segment has four parts in a fixed order. It starts with a run of zero bits, then the stored word, then a hard-wired 4-bit revision code, then an alternating check pattern. The length of the zero run and the length of the check pattern depend on the format bit, which is bit 0 of the stored word. The whole segment is sent twice back to back.

The conversion strobe must stay still during readback. If it moves, the readback is aborted and a sticky protocol error is raised. Once a readback has completed, a falling edge of the strobe starts normal operation. If the host does not want the readback, it can start a new write, which cuts the readback short without any error.

Top module: `cfgReadbackSeq`

## Requirements
- R1: A word is committed only after 16 consecutive clock edges with `wrEn` high, and the first bit received becomes bit 15 of the word. If `wrEn` drops earlier, the partial bits are discarded and no readback starts. After the committing edge, `rbBusy` is 1 and `sdo` shows frame bit 0.
- R2: Each segment opens with zero bits: 256 of them when bit 0 of the stored word is 0, and 320 when it is 1.
- R3: The zero run is followed by the stored word, MSB first, and then the revision code `REV_ID` (default 4'hA), MSB first.
- R4: The check pattern follows the revision code and alternates 1,0,1,0,… starting with 1. It is 236 bits long for format 0 and 300 bits long for format 1.
- R5: The segment is sent twice, for a total of 1024 bits (format 0) or 1280 bits (format 1). After the last bit, `rbBusy` is 0 and `sdo` is 0.
- R6: `sdo` changes only on rising clock edges. Frame bit i is visible after the i-th edge that follows the committing edge.
- R7: If `conv` differs from its value at the previous edge while `rbBusy` is 1 and `wrEn` is 0, then after that edge `rbBusy` is 0, `sdo` is 0 and `protoErr` is 1.
- R8: `protoErr` stays 1 until the next committed write, which clears it.
- R9: `normActive` goes to 1 on a falling edge of `conv` seen after a readback has fully completed. It is not set during readback or after an aborted readback, and it is cleared by `wrEn`.
- R10: Raising `wrEn` during readback ends the readback with `sdo` low and no error, even when `conv` toggles at the same edge.
- R11: While `rstN` is low at a rising edge, the block goes idle with `sdo`, `rbBusy`, `protoErr` and `normActive` all 0.
- R12: A `conv` toggle on the edge that would end the readback counts as an abort. `protoErr` is set and normal operation cannot start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host data clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| sdi | input | 1 | Serial configuration data in |
| wrEn | input | 1 | Write enable for configuration shifting |
| conv | input | 1 | Conversion strobe |
| sdo | output | 1 | Serial readback data out |
| rbBusy | output | 1 | Readback in progress |
| protoErr | output | 1 | Sticky error: strobe moved during readback |
| normActive | output | 1 | Normal operation started |

## Verification
Two pairs of functions can fall on the same edge. The bench drives both pairs onto one edge and checks the outcome. First, a strobe toggle can land on the edge that would close the readback. The bench clocks exactly one bit short of the frame length, flips `conv` on the next edge, and expects an error with no completion, so a later strobe fall must not start normal operation. Second, a strobe toggle can coincide with a new write that interrupts a readback. The bench raises `wrEn` and flips `conv` on the same edge, expects no error, and then checks that the readback of the new word is bit-exact.

// File: rtl/cfgrb_pkg.sv
package cfgrb_pkg;

  // Width of the in-segment position counter; must cover the longest segment.
  localparam int unsigned POS_W = 12;

  typedef struct packed {
    logic             shiftIn;  // shift sdi into the capture register
    logic             commit;   // store captured word
    logic             emit;     // drive frame bit at pos onto sdo
    logic [POS_W-1:0] pos;      // frame position to drive
  } rbStrobe_t;

endpackage

// File: rtl/cfgrb_ctrl.sv
module cfgrb_ctrl
  import cfgrb_pkg::*;
#(
  parameter int unsigned CFG_W      = 16,
  parameter int unsigned REV_W      = 4,
  parameter int unsigned ZERO_F0    = 256,
  parameter int unsigned ZERO_F1    = 320,
  parameter int unsigned CHK_F0     = 236,
  parameter int unsigned CHK_F1     = 300,
  parameter int unsigned SEG_REPEAT = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      wrEn,
  input  logic      conv,
  input  logic      fmtBit,
  output rbStrobe_t strobe,
  output logic      rbBusy,
  output logic      protoErr,
  output logic      normActive
);

  localparam int unsigned WC_W   = $clog2(CFG_W);
  localparam int unsigned SEG_W  = $clog2(SEG_REPEAT + 1);
  localparam int unsigned SEG_L0 = ZERO_F0 + CFG_W + REV_W + CHK_F0;
  localparam int unsigned SEG_L1 = ZERO_F1 + CFG_W + REV_W + CHK_F1;
  localparam logic [WC_W-1:0]  WC_LAST  = WC_W'(CFG_W - 1);
  localparam logic [POS_W-1:0] LAST_L0  = POS_W'(SEG_L0 - 1);
  localparam logic [POS_W-1:0] LAST_L1  = POS_W'(SEG_L1 - 1);
  localparam logic [SEG_W-1:0] SEG_LAST = SEG_W'(SEG_REPEAT - 1);

  logic [WC_W-1:0]  wrCnt;
  logic [POS_W-1:0] pos;
  logic [POS_W-1:0] nextPos;
  logic [SEG_W-1:0] seg;
  logic             convPrev;
  logic             done;
  logic             commit;
  logic             abortConv;
  logic             atSegEnd;
  logic             atFrameEnd;
  logic [POS_W-1:0] segLast;

  always_comb begin
    segLast    = fmtBit ? LAST_L1 : LAST_L0;
    commit     = wrEn && (wrCnt == WC_LAST);
    abortConv  = rbBusy && !wrEn && (conv != convPrev);
    atSegEnd   = (pos == segLast);
    atFrameEnd = atSegEnd && (seg == SEG_LAST);
    if (commit || atSegEnd) nextPos = '0;
    else                    nextPos = pos + 1'b1;
    strobe.shiftIn = wrEn;
    strobe.commit  = commit;
    strobe.emit    = commit || (rbBusy && !wrEn && !abortConv && !atFrameEnd);
    strobe.pos     = nextPos;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrCnt      <= '0;
      pos        <= '0;
      seg        <= '0;
      convPrev   <= 1'b0;
      done       <= 1'b0;
      rbBusy     <= 1'b0;
      protoErr   <= 1'b0;
      normActive <= 1'b0;
    end else begin
      convPrev <= conv;
      if (wrEn) begin
        wrCnt      <= commit ? '0 : wrCnt + 1'b1;
        done       <= 1'b0;
        normActive <= 1'b0;
        if (commit) begin
          rbBusy   <= 1'b1;
          pos      <= '0;
          seg      <= '0;
          protoErr <= 1'b0;
        end else begin
          rbBusy <= 1'b0;
        end
      end else begin
        wrCnt <= '0;
        if (rbBusy) begin
          if (abortConv) begin
            rbBusy   <= 1'b0;
            protoErr <= 1'b1;
          end else if (atFrameEnd) begin
            rbBusy <= 1'b0;
            done   <= 1'b1;
          end else begin
            pos <= nextPos;
            if (atSegEnd) seg <= seg + 1'b1;
          end
        end else if (done && convPrev && !conv) begin
          normActive <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/cfgrb_dp.sv
module cfgrb_dp
  import cfgrb_pkg::*;
#(
  parameter int unsigned CFG_W   = 16,
  parameter int unsigned REV_W   = 4,
  parameter logic [REV_W-1:0] REV_ID = 4'hA,
  parameter int unsigned FMT_BIT = 0,
  parameter int unsigned ZERO_F0 = 256,
  parameter int unsigned ZERO_F1 = 320
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sdi,
  input  rbStrobe_t strobe,
  output logic      fmtBit,
  output logic      sdo
);

  localparam logic [POS_W-1:0] Z0     = POS_W'(ZERO_F0);
  localparam logic [POS_W-1:0] Z1     = POS_W'(ZERO_F1);
  localparam logic [POS_W-1:0] CFG_LN = POS_W'(CFG_W);
  localparam logic [POS_W-1:0] REV_LN = POS_W'(REV_W);

  logic [CFG_W-1:0] shiftReg;
  logic [CFG_W-1:0] cfgReg;
  logic [CFG_W-1:0] captured;
  logic [CFG_W-1:0] cfgShifted;
  logic [REV_W-1:0] revShifted;
  logic [POS_W-1:0] zLen;
  logic [POS_W-1:0] rel;
  logic             frameBit;

  assign captured = {shiftReg[CFG_W-2:0], sdi};
  assign fmtBit   = cfgReg[FMT_BIT];

  always_comb begin
    zLen       = fmtBit ? Z1 : Z0;
    rel        = '0;
    cfgShifted = '0;
    revShifted = '0;
    frameBit   = 1'b0;
    if (strobe.pos < zLen) begin
      frameBit = 1'b0;
    end else if (strobe.pos < zLen + CFG_LN) begin
      rel        = strobe.pos - zLen;
      cfgShifted = cfgReg << rel;
      frameBit   = cfgShifted[CFG_W-1];
    end else if (strobe.pos < zLen + CFG_LN + REV_LN) begin
      rel        = strobe.pos - zLen - CFG_LN;
      revShifted = REV_ID << rel;
      frameBit   = revShifted[REV_W-1];
    end else begin
      rel      = strobe.pos - zLen - CFG_LN - REV_LN;
      frameBit = ~rel[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      cfgReg   <= '0;
      sdo      <= 1'b0;
    end else begin
      if (strobe.shiftIn) shiftReg <= captured;
      if (strobe.commit)  cfgReg   <= captured;
      sdo <= strobe.emit ? frameBit : 1'b0;
    end
  end

endmodule

// File: rtl/cfgReadbackSeq.sv
module cfgReadbackSeq
  import cfgrb_pkg::*;
#(
  parameter int unsigned CFG_W      = 16,
  parameter int unsigned REV_W      = 4,
  parameter logic [REV_W-1:0] REV_ID = 4'hA,
  parameter int unsigned FMT_BIT    = 0,
  parameter int unsigned ZERO_F0    = 256,
  parameter int unsigned ZERO_F1    = 320,
  parameter int unsigned CHK_F0     = 236,
  parameter int unsigned CHK_F1     = 300,
  parameter int unsigned SEG_REPEAT = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sdi,
  input  logic wrEn,
  input  logic conv,
  output logic sdo,
  output logic rbBusy,
  output logic protoErr,
  output logic normActive
);

  rbStrobe_t strobe;
  logic      fmtBit;

  cfgrb_ctrl #(
    .CFG_W(CFG_W), .REV_W(REV_W), .ZERO_F0(ZERO_F0), .ZERO_F1(ZERO_F1),
    .CHK_F0(CHK_F0), .CHK_F1(CHK_F1), .SEG_REPEAT(SEG_REPEAT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .conv(conv), .fmtBit(fmtBit),
    .strobe(strobe), .rbBusy(rbBusy), .protoErr(protoErr),
    .normActive(normActive)
  );

  cfgrb_dp #(
    .CFG_W(CFG_W), .REV_W(REV_W), .REV_ID(REV_ID), .FMT_BIT(FMT_BIT),
    .ZERO_F0(ZERO_F0), .ZERO_F1(ZERO_F1)
  ) u_dp (
    .clk(clk), .rstN(rstN), .sdi(sdi), .strobe(strobe),
    .fmtBit(fmtBit), .sdo(sdo)
  );

endmodule

// File: rtl/cfgrb_chk.sv
module cfgrb_chk (
  input logic clk,
  input logic rstN,
  input logic wrEn,
  input logic conv,
  input logic sdo,
  input logic rbBusy,
  input logic protoErr,
  input logic normActive
);

  logic convQ;
  always_ff @(posedge clk) convQ <= conv;

  // R5
  sdo_idle_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rbBusy |-> !sdo);

  // R7
  conv_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rbBusy && !wrEn && (conv != convQ)) |=> (protoErr && !rbBusy));

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (protoErr && !wrEn) |=> protoErr);

  // R1
  busy_after_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rbBusy) |-> $past(wrEn));

  // R9
  norm_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(normActive) |-> ($past(convQ) && !$past(conv) && !$past(rbBusy)));

  // R10
  write_stops_rb_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rbBusy && wrEn) |=> (!sdo && !protoErr));

endmodule

bind cfgReadbackSeq cfgrb_chk u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .conv(conv), .sdo(sdo),
  .rbBusy(rbBusy), .protoErr(protoErr), .normActive(normActive)
);

// File: tb/cfgReadbackSeq_tb.sv
module cfgReadbackSeq_tb;

  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] REV = 4'hA;
  localparam int NVEC = 4;
  localparam logic [15:0] VEC_WORD [NVEC] = '{16'hA5A4, 16'h3C3D, 16'hFFFF, 16'h0000};
  localparam int          VEC_LEN  [NVEC] = '{1024, 1280, 1280, 1024};

  logic clk = 1'b0;
  logic rstN, sdi, wrEn, conv;
  logic sdo, rbBusy, protoErr, normActive;
  int compared = 0;
  int mismatched = 0;
  logic convLvl = 1'b0;

  cfgReadbackSeq u_dut (
    .clk(clk), .rstN(rstN), .sdi(sdi), .wrEn(wrEn), .conv(conv),
    .sdo(sdo), .rbBusy(rbBusy), .protoErr(protoErr), .normActive(normActive)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    finishRun();
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // drive at negedge, return at next negedge (outputs settled from posedge)
  task automatic tick(input logic w, input logic d, input logic c);
    wrEn = w; sdi = d; conv = c;
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic expBit(input logic [15:0] w, input int idx);
    int z, chkL, segL, p;
    z    = w[0] ? 320 : 256;
    chkL = w[0] ? 300 : 236;
    segL = z + 16 + 4 + chkL;
    p    = idx % segL;
    if (p < z) return 1'b0;
    if (p < z + 16) return w[15 - (p - z)];
    if (p < z + 20) return REV[3 - (p - z - 16)];
    return ((p - z - 20) % 2) == 0;
  endfunction

  task automatic writeWord(input logic [15:0] w);
    for (int i = 15; i >= 0; i--) tick(1'b1, w[i], convLvl);
  endtask

  // Called right after the committing edge.
  task automatic readCheck(input logic [15:0] w, input int expLen, input string tag);
    int bad = 0;
    int firstBad = -1;
    int firstAct = 0;
    for (int i = 0; i < expLen; i++) begin
      if (i > 0) tick(1'b0, 1'b0, convLvl);
      if (rbBusy !== 1'b1 || sdo !== expBit(w, i)) begin
        if (firstBad < 0) begin firstBad = i; firstAct = int'(sdo); end
        bad++;
      end
    end
    chk(bad == 0, tag, $sformatf("frame word %h bad bits (first idx %0d sdo=%0d)",
        w, firstBad, firstAct), bad, 0);
    tick(1'b0, 1'b0, convLvl);
    chk(rbBusy === 1'b0 && sdo === 1'b0, "R5", "end of frame busy/sdo",
        int'({rbBusy, sdo}), 0);
  endtask

  initial begin
    rstN = 1'b0; wrEn = 1'b0; sdi = 1'b0; conv = 1'b0;
    @(negedge clk);
    tick(1'b0, 1'b0, 1'b0);
    tick(1'b0, 1'b0, 1'b0);
    // R11 reset state
    chk({sdo, rbBusy, protoErr, normActive} === 4'b0, "R11", "reset outputs",
        int'({sdo, rbBusy, protoErr, normActive}), 0);
    rstN = 1'b1;
    tick(1'b0, 1'b0, 1'b0);

    // Vector table: R1 R2 R3 R4 R5 R6
    for (int v = 0; v < NVEC; v++) begin
      writeWord(VEC_WORD[v]);
      chk(rbBusy === 1'b1 && sdo === 1'b0, "R1", "busy/bit0 after commit",
          int'({rbBusy, sdo}), 2);
      readCheck(VEC_WORD[v], VEC_LEN[v], (VEC_WORD[v][0]) ? "R2/R4 fmt1" : "R3/R6 fmt0");
    end

    // R9: conv rise then fall after completed readback starts normal op
    convLvl = 1'b1; tick(1'b0, 1'b0, convLvl);
    chk(normActive === 1'b0, "R9", "no start on rising conv", int'(normActive), 0);
    convLvl = 1'b0; tick(1'b0, 1'b0, convLvl);
    chk(normActive === 1'b1, "R9", "start on conv fall", int'(normActive), 1);

    // R9: wrEn clears normActive
    tick(1'b1, 1'b0, convLvl);
    chk(normActive === 1'b0, "R9", "wrEn clears normActive", int'(normActive), 0);
    tick(1'b0, 1'b0, convLvl);

    // R1: partial write discarded (10 bits, gap, 6 bits -> no commit)
    for (int i = 0; i < 10; i++) tick(1'b1, 1'b1, convLvl);
    tick(1'b0, 1'b0, convLvl);
    for (int i = 0; i < 6; i++) tick(1'b1, 1'b1, convLvl);
    tick(1'b0, 1'b0, convLvl);
    chk(rbBusy === 1'b0, "R1", "partial write no readback", int'(rbBusy), 0);

    // R7: conv toggle mid-readback aborts
    writeWord(16'h1234);
    repeat (40) tick(1'b0, 1'b0, convLvl);
    convLvl = 1'b1; tick(1'b0, 1'b0, convLvl);
    chk({rbBusy, sdo, protoErr} === 3'b001, "R7", "abort busy/sdo/err",
        int'({rbBusy, sdo, protoErr}), 1);

    // R8 sticky, R9 no start after abort
    convLvl = 1'b0; tick(1'b0, 1'b0, convLvl);
    repeat (5) tick(1'b0, 1'b0, convLvl);
    chk(protoErr === 1'b1, "R8", "error sticky", int'(protoErr), 1);
    chk(normActive === 1'b0, "R9", "no start after aborted readback", int'(normActive), 0);

    // R8: next committed write clears error
    writeWord(16'h0F0E);
    chk(protoErr === 1'b0, "R8", "write clears error", int'(protoErr), 0);

    // R11: reset mid-readback
    repeat (20) tick(1'b0, 1'b0, convLvl);
    rstN = 1'b0; tick(1'b0, 1'b0, convLvl);
    chk({sdo, rbBusy, protoErr, normActive} === 4'b0, "R11", "reset mid readback",
        int'({sdo, rbBusy, protoErr, normActive}), 0);
    rstN = 1'b1; tick(1'b0, 1'b0, convLvl);

    // R12: conv toggle on the final edge
    writeWord(16'h5554);
    repeat (1023) tick(1'b0, 1'b0, convLvl);
    chk(rbBusy === 1'b1, "R12", "still busy before final edge", int'(rbBusy), 1);
    convLvl = 1'b1; tick(1'b0, 1'b0, convLvl);
    chk(protoErr === 1'b1 && rbBusy === 1'b0, "R12", "final-edge toggle is error",
        int'({protoErr, rbBusy}), 2);
    convLvl = 1'b0; tick(1'b0, 1'b0, convLvl);
    chk(normActive === 1'b0, "R12", "no start after final-edge abort", int'(normActive), 0);

    // R10: new write with simultaneous conv toggle during readback
    writeWord(16'hC3C2);
    repeat (5) tick(1'b0, 1'b0, convLvl);
    convLvl = 1'b1;
    tick(1'b1, 1'b1, convLvl);  // bit 15 of 16'h9ABD is 1
    chk({rbBusy, sdo, protoErr} === 3'b000, "R10", "write wins over conv",
        int'({rbBusy, sdo, protoErr}), 0);
    for (int i = 14; i >= 0; i--) tick(1'b1, 16'h9ABD >> i, convLvl);
    readCheck(16'h9ABD, 1280, "R10");
    chk(protoErr === 1'b0, "R10", "no error after interrupted readback", int'(protoErr), 0);

    finishRun();
  end

endmodule